// File: doc/BRIEF.md
# Paged address translation map

This block sits between a network controller (or the host) and on-board RAM. It turns a 24-bit bus address into a physical RAM address by looking it up in a writable page map. The map has 1024 slots. Address bits [19:10] pick the slot, and address bits [9:0] go through unchanged as the byte offset within a 1 KiB page. The top four address bits are ignored, so the whole 24-bit space folds onto 20 bits. Because of this folding, the fixed-address startup pointer near the top of the space can be placed on any physical page.

Each map entry holds three things:
- a 12-bit page frame number;
- a select bit that chooses between the external expansion bus and on-board memory;
- a byte-order bit that exchanges the two bytes of a 16-bit word between the bus and RAM.

On-board memory has 256 pages, so only the low 8 frame bits reach it. The host loads and reads entries through a 16-bit register port. The same map serves controller and host accesses alike.

A request is registered together with its map lookup. The translated address, memory select, swapped write data and byte-lane enables appear one clock later. Read data coming back from RAM is swapped under the same entry's byte-order bit.

Top module: `pmap_xlate`

## Requirements
- R1: The low 10 bits of the translated address `xl_addr[9:0]` equal `req_addr[9:0]` of the request.
- R2: The map slot is `req_addr[19:10]`, and `req_addr[23:20]` has no effect on the result. Address 0xFFFFF4 is translated through slot 1023 at offset 0x3F4.
- R3: An entry in register format is laid out as follows: bit 15 is the byte-order swap, bit 13 selects external memory when 1, and bits [11:0] are the frame. For an external entry, `xl_addr` is {frame[11:0], offset[9:0]} (22 bits), `xl_ext` is 1, and `xl_swap` equals bit 15.
- R4: For an on-board entry (bit 13 = 0), `xl_ext` is 0 and `xl_addr[21:18]` is zero, so only frame bits [7:0] are used.
- R5: With the swap bit set, `xl_wdata` is `req_wdata` with its two bytes exchanged, and `bus_rdata` is `ram_rdata` with its bytes exchanged. With the swap bit clear, both pass straight through.
- R6: A word access (`req_byte`=0) gives `xl_lane_en`=2'b11. A byte access enables only lane `req_addr[0]` XOR swap, where lane 0 is data bits [7:0] (2'b01) and lane 1 is bits [15:8] (2'b10).
- R7: `xl_valid` is high exactly one clock after a cycle with `req_valid` high. The outputs in that cycle belong to that request. `xl_valid` is 0 after reset.
- R8: Writing with `map_wr` stores `map_wdata` at slot `map_idx`. `map_rdata` shows the entry at `map_idx` one clock after it is presented, with bits 14 and 12 reading as zero.
- R9: A lookup in the same cycle as a map write to the same slot uses the old entry, and the host read in that cycle also returns the old entry. The next lookup uses the new entry.
- R10: Two slots that hold the same entry translate to the same physical page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the request pipeline |
| map_wr | input | 1 | Write strobe for the page map |
| map_idx | input | 10 | Slot addressed by the host port |
| map_wdata | input | 16 | Entry value to write |
| map_rdata | output | 16 | Registered read-back of slot `map_idx` |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 24 | Bus address to translate |
| req_byte | input | 1 | 1 for a byte access, 0 for a word access |
| req_wdata | input | 16 | Write data as seen on the bus |
| xl_valid | output | 1 | Translated request is valid |
| xl_addr | output | 22 | Physical address {frame, offset} |
| xl_ext | output | 1 | 1 selects external-bus memory, 0 on-board |
| xl_swap | output | 1 | Byte-order swap in force for this access |
| xl_lane_en | output | 2 | RAM byte-lane enables |
| xl_wdata | output | 16 | Write data in RAM byte order |
| ram_rdata | input | 16 | Read data from RAM |
| bus_rdata | output | 16 | Read data in bus byte order |

## Verification
The main path is run through a table of requests.

**Entries covered:**
- a swapping on-board entry;
- a plain external entry;
- an on-board entry whose frame has stray high bits;
- an all-ones entry.

**Addresses covered:** the first slot, a middle page, the last slot at 0xFFFFF4, and an address whose top nibble is non-zero.

**What the table tells apart:** a wrong slot field, a failure to ignore the top nibble, missing on-board masking, and a swap applied to the wrong direction. Byte accesses on both address parities, with and without the swap, separate an XOR lane select from a plain one.

**Directed cases:** the read-back of reserved bits, two aliased slots, and a same-slot write colliding with a lookup, which distinguishes old-entry from new-entry forwarding.

// File: rtl/pmap_pkg.sv
package pmap_pkg;

   localparam int REG_W    = 16;
   localparam int SWAP_POS = 15;
   localparam int EXT_POS  = 13;
   localparam int FRAME_W  = 12;

   typedef struct packed {
      logic               swap;
      logic               ext;
      logic [FRAME_W-1:0] frame;
   } map_ent_t;

   localparam int ENT_W = $bits(map_ent_t);

   function automatic map_ent_t ent_from_reg(input logic [REG_W-1:0] r);
      map_ent_t e;
      e.swap  = r[SWAP_POS];
      e.ext   = r[EXT_POS];
      e.frame = r[FRAME_W-1:0];
      return e;
   endfunction

   function automatic logic [REG_W-1:0] ent_to_reg(input map_ent_t e);
      logic [REG_W-1:0] r;
      r                = '0;
      r[SWAP_POS]      = e.swap;
      r[EXT_POS]       = e.ext;
      r[FRAME_W-1:0]   = e.frame;
      return r;
   endfunction

endpackage

// File: rtl/pmap_table.sv
module pmap_table
   import pmap_pkg::*;
#(
   parameter int SLOT_BITS = 10
) (
   input  logic                 clk,
   input  logic                 wr_en,
   input  logic [SLOT_BITS-1:0] wr_idx,
   input  map_ent_t             wr_ent,
   input  logic                 lk_en,
   input  logic [SLOT_BITS-1:0] lk_idx,
   output map_ent_t             lk_ent,
   input  logic [SLOT_BITS-1:0] hr_idx,
   output map_ent_t             hr_ent
);

   localparam int DEPTH = 1 << SLOT_BITS;

   if (SLOT_BITS < 1 || SLOT_BITS > 12) begin : g_bad_depth
      $error("pmap_table: SLOT_BITS out of range");
   end

   map_ent_t store [DEPTH];

   // Reads sample the array before the write of the same edge lands,
   // so a colliding lookup sees the previous entry.
   always_ff @(posedge clk) begin
      if (wr_en) begin
         store[wr_idx] <= wr_ent;
      end
      if (lk_en) begin
         lk_ent <= store[lk_idx];
      end
      hr_ent <= store[hr_idx];
   end

endmodule

// File: rtl/pmap_lane.sv
module pmap_lane #(
   parameter int DATA_W = 16
) (
   input  logic              swap,
   input  logic              byte_acc,
   input  logic              addr_lsb,
   input  logic [DATA_W-1:0] wd_bus,
   output logic [DATA_W-1:0] wd_ram,
   input  logic [DATA_W-1:0] rd_ram,
   output logic [DATA_W-1:0] rd_bus,
   output logic [DATA_W/8-1:0] lane_en
);

   localparam int LANES = DATA_W / 8;

   if (LANES != 2 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("pmap_lane: only a two-lane data path is supported");
   end

   logic lane_sel;
   assign lane_sel = addr_lsb ^ swap;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int MIR = LANES - 1 - i;
      assign wd_ram[i*8 +: 8] = swap ? wd_bus[MIR*8 +: 8] : wd_bus[i*8 +: 8];
      assign rd_bus[i*8 +: 8] = swap ? rd_ram[MIR*8 +: 8] : rd_ram[i*8 +: 8];
      assign lane_en[i]       = !byte_acc || (lane_sel == 1'(i));
   end

endmodule

// File: rtl/pmap_xlate.sv
module pmap_xlate
   import pmap_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int PAGE_BITS   = 10,
   parameter int SLOT_BITS   = 10,
   parameter int ONB_FRAME_W = 8,
   parameter int DATA_W      = 16,
   localparam int PHYS_W     = FRAME_W + PAGE_BITS,
   localparam int LANES      = DATA_W / 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 map_wr,
   input  logic [SLOT_BITS-1:0] map_idx,
   input  logic [REG_W-1:0]     map_wdata,
   output logic [REG_W-1:0]     map_rdata,
   input  logic                 req_valid,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic                 req_byte,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 xl_valid,
   output logic [PHYS_W-1:0]    xl_addr,
   output logic                 xl_ext,
   output logic                 xl_swap,
   output logic [LANES-1:0]     xl_lane_en,
   output logic [DATA_W-1:0]    xl_wdata,
   input  logic [DATA_W-1:0]    ram_rdata,
   output logic [DATA_W-1:0]    bus_rdata
);

   localparam int SLOT_LO = PAGE_BITS;
   localparam int SLOT_HI = PAGE_BITS + SLOT_BITS - 1;

   if (SLOT_HI >= ADDR_W) begin : g_bad_addr
      $error("pmap_xlate: page and slot fields exceed the address width");
   end
   if (ONB_FRAME_W < 1 || ONB_FRAME_W > FRAME_W) begin : g_bad_onb
      $error("pmap_xlate: ONB_FRAME_W must lie in 1..FRAME_W");
   end

   // The address bits above the slot field are folded away by design.
   if (SLOT_HI + 1 < ADDR_W) begin : g_fold
      logic unused_hi;
      assign unused_hi = ^req_addr[ADDR_W-1:SLOT_HI+1];
   end

   // Page map storage.
   map_ent_t lk_ent;
   map_ent_t hr_ent;

   pmap_table #(.SLOT_BITS(SLOT_BITS)) u_table (
      .clk    (clk),
      .wr_en  (map_wr),
      .wr_idx (map_idx),
      .wr_ent (ent_from_reg(map_wdata)),
      .lk_en  (req_valid),
      .lk_idx (req_addr[SLOT_HI:SLOT_LO]),
      .lk_ent (lk_ent),
      .hr_idx (map_idx),
      .hr_ent (hr_ent)
   );

   assign map_rdata = ent_to_reg(hr_ent);

   // Request stage, aligned with the registered lookup.
   logic                 v_q;
   logic [PAGE_BITS-1:0] off_q;
   logic                 byte_q;
   logic [DATA_W-1:0]    wd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= 1'b0;
      end else begin
         v_q <= req_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (req_valid) begin
         off_q  <= req_addr[PAGE_BITS-1:0];
         byte_q <= req_byte;
         wd_q   <= req_wdata;
      end
   end

   // Frame selection: on-board memory decodes only its own page count.
   logic [FRAME_W-1:0] frame_eff;

   if (ONB_FRAME_W < FRAME_W) begin : g_onb_mask
      assign frame_eff = lk_ent.ext
                       ? lk_ent.frame
                       : {{(FRAME_W-ONB_FRAME_W){1'b0}}, lk_ent.frame[ONB_FRAME_W-1:0]};
   end else begin : g_onb_full
      assign frame_eff = lk_ent.frame;
   end

   assign xl_valid = v_q;
   assign xl_addr  = {frame_eff, off_q};
   assign xl_ext   = lk_ent.ext;
   assign xl_swap  = lk_ent.swap;

   // Byte-order and lane handling.
   pmap_lane #(.DATA_W(DATA_W)) u_lane (
      .swap     (lk_ent.swap),
      .byte_acc (byte_q),
      .addr_lsb (off_q[0]),
      .wd_bus   (wd_q),
      .wd_ram   (xl_wdata),
      .rd_ram   (ram_rdata),
      .rd_bus   (bus_rdata),
      .lane_en  (xl_lane_en)
   );

endmodule

// File: rtl/pmap_xlate_chk.sv
module pmap_xlate_chk #(
   parameter int PAGE_BITS   = 10,
   parameter int ONB_FRAME_W = 8,
   parameter int PHYS_W      = 22,
   parameter int DATA_W      = 16,
   parameter int LANES       = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [PAGE_BITS-1:0] req_off,
   input logic                 req_byte,
   input logic                 xl_valid,
   input logic [PHYS_W-1:0]    xl_addr,
   input logic                 xl_ext,
   input logic [LANES-1:0]     xl_lane_en,
   input logic [DATA_W-1:0]    ram_rdata,
   input logic [DATA_W-1:0]    bus_rdata
);

   // R7: a request yields a valid result on the next clock
   p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> xl_valid);

   // R7: no request, no result
   p_idle_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !xl_valid);

   // R1: page offset passes through untouched
   p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> xl_addr[PAGE_BITS-1:0] == $past(req_off));

   // R4: on-board accesses never reach beyond the on-board page count
   p_onboard_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_valid && !xl_ext) |-> ((xl_addr >> (PAGE_BITS + ONB_FRAME_W)) == '0));

   // R6: word accesses drive every lane
   p_lane_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_byte) |=> (xl_lane_en == '1));

   // R6: byte accesses drive exactly one lane
   p_lane_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_byte) |=> ($countones(xl_lane_en) == 1));

   // R5: the read path only rearranges bytes, never alters bits
   p_read_perm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xl_valid |-> ($countones(bus_rdata) == $countones(ram_rdata)));

endmodule

bind pmap_xlate pmap_xlate_chk #(
   .PAGE_BITS   (PAGE_BITS),
   .ONB_FRAME_W (ONB_FRAME_W),
   .PHYS_W      (PHYS_W),
   .DATA_W      (DATA_W),
   .LANES       (LANES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_off    (req_addr[PAGE_BITS-1:0]),
   .req_byte   (req_byte),
   .xl_valid   (xl_valid),
   .xl_addr    (xl_addr),
   .xl_ext     (xl_ext),
   .xl_lane_en (xl_lane_en),
   .ram_rdata  (ram_rdata),
   .bus_rdata  (bus_rdata)
);

// File: tb/tb_pmap_xlate.sv
module tb_pmap_xlate;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        map_wr;
   logic [9:0]  map_idx;
   logic [15:0] map_wdata;
   logic [15:0] map_rdata;
   logic        req_valid;
   logic [23:0] req_addr;
   logic        req_byte;
   logic [15:0] req_wdata;
   logic        xl_valid;
   logic [21:0] xl_addr;
   logic        xl_ext;
   logic        xl_swap;
   logic [1:0]  xl_lane_en;
   logic [15:0] xl_wdata;
   logic [15:0] ram_rdata;
   logic [15:0] bus_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 4 ns period, 250 MHz

   pmap_xlate dut (
      .clk(clk), .rst_n(rst_n),
      .map_wr(map_wr), .map_idx(map_idx), .map_wdata(map_wdata), .map_rdata(map_rdata),
      .req_valid(req_valid), .req_addr(req_addr), .req_byte(req_byte), .req_wdata(req_wdata),
      .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_ext(xl_ext), .xl_swap(xl_swap),
      .xl_lane_en(xl_lane_en), .xl_wdata(xl_wdata),
      .ram_rdata(ram_rdata), .bus_rdata(bus_rdata)
   );

   typedef struct packed {
      logic [23:0] addr;
      logic [15:0] wd;
      logic        byt;
      logic [21:0] e_addr;
      logic        e_ext;
      logic        e_swap;
      logic [15:0] e_wd;
      logic [1:0]  e_lane;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VEC [NVEC] = '{
      '{24'h000012, 16'h1234, 1'b0, 22'h001412, 1'b0, 1'b1, 16'h3412, 2'b11},
      '{24'h000401, 16'hAA00, 1'b1, 22'h2AF001, 1'b1, 1'b0, 16'hAA00, 2'b10},
      '{24'h000BFE, 16'hBEEF, 1'b0, 22'h000FFE, 1'b0, 1'b0, 16'hBEEF, 2'b11},
      '{24'h000C00, 16'h0077, 1'b1, 22'h3FFC00, 1'b1, 1'b1, 16'h7700, 2'b10},
      '{24'hFFFFF4, 16'h5555, 1'b0, 22'h0003F4, 1'b0, 1'b0, 16'h5555, 2'b11},
      '{24'h5003F4, 16'h00C3, 1'b1, 22'h0017F4, 1'b0, 1'b1, 16'hC300, 2'b10},
      '{24'hA00C01, 16'h9900, 1'b1, 22'h3FFC01, 1'b1, 1'b1, 16'h0099, 2'b01},
      '{24'h001005, 16'h0102, 1'b0, 22'h000005, 1'b0, 1'b0, 16'h0102, 2'b11}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic map_write(input logic [9:0] idx, input logic [15:0] val);
      @(negedge clk);
      map_wr    = 1'b1;
      map_idx   = idx;
      map_wdata = val;
      @(negedge clk);
      map_wr    = 1'b0;
   endtask

   task automatic map_check(input logic [9:0] idx, input logic [15:0] exp);
      @(negedge clk);
      map_idx = idx;
      @(negedge clk);
      chk("R8 map read-back", {16'h0, map_rdata}, {16'h0, exp});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n     = 1'b0;
      map_wr    = 1'b0;
      map_idx   = '0;
      map_wdata = '0;
      req_valid = 1'b0;
      req_addr  = '0;
      req_byte  = 1'b0;
      req_wdata = '0;
      ram_rdata = 16'hA1B2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7 reset valid", {31'h0, xl_valid}, 32'h0);

      map_write(10'd0,    16'h8005);
      map_write(10'd1,    16'h2ABC);
      map_write(10'd2,    16'h0F03);
      map_write(10'd3,    16'hFFFF);
      map_write(10'd4,    16'h0000);
      map_write(10'd1023, 16'h0000);
      map_write(10'd5,    16'h0001);

      // R8: stored fields come back, reserved bits 14 and 12 read zero
      map_check(10'd0, 16'h8005);
      map_check(10'd2, 16'h0F03);
      map_check(10'd3, 16'hAFFF);

      // Table walk: R1 R2 R3 R4 R5 R6 R10
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         req_valid = 1'b1;
         req_addr  = VEC[i].addr;
         req_wdata = VEC[i].wd;
         req_byte  = VEC[i].byt;
         @(negedge clk);
         req_valid = 1'b0;
         chk("R7 valid",          {31'h0, xl_valid},  32'h1);
         chk("R1/R2/R3/R4 addr",  {10'h0, xl_addr},   {10'h0, VEC[i].e_addr});
         chk("R3/R4 ext",         {31'h0, xl_ext},    {31'h0, VEC[i].e_ext});
         chk("R3 swap",           {31'h0, xl_swap},   {31'h0, VEC[i].e_swap});
         chk("R5 write data",     {16'h0, xl_wdata},  {16'h0, VEC[i].e_wd});
         chk("R6 lanes",          {30'h0, xl_lane_en}, {30'h0, VEC[i].e_lane});
         chk("R5 read data",      {16'h0, bus_rdata},
             {16'h0, VEC[i].e_swap ? 16'hB2A1 : 16'hA1B2});
      end
      @(negedge clk);
      chk("R7 idle valid", {31'h0, xl_valid}, 32'h0);

      // R10: slots 4 and 1023 hold the same entry
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = 24'h0FFC20;
      req_byte  = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 alias slot 1023", {10'h0, xl_addr}, 32'h000020);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = 24'h001020;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 alias slot 4", {10'h0, xl_addr}, 32'h000020);

      // R9: write to slot 5 collides with a lookup of slot 5
      @(negedge clk);
      map_wr    = 1'b1;
      map_idx   = 10'd5;
      map_wdata = 16'h0002;
      req_valid = 1'b1;
      req_addr  = 24'h001400;
      @(negedge clk);
      map_wr = 1'b0;
      chk("R9 collide old entry", {10'h0, xl_addr}, 32'h000400);
      chk("R9 host read old entry", {16'h0, map_rdata}, 32'h0001);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 next lookup new entry", {10'h0, xl_addr}, 32'h000800);
      chk("R8 host read new entry", {16'h0, map_rdata}, 32'h0002);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule